// File: doc/BRIEF.md
# Configuration Address/Data Port Bridge

This block gives a host processor indirect access to device configuration space through two registers. The host first writes a 32-bit target word into the address port. That word holds an enable flag, a bus number, a device/function number and a register offset. Each later access to the data port becomes one downstream configuration read or write. The request carries the bus, the device/function, a byte offset into the 256-byte configuration space and a byte count.

The offset sent downstream combines the dword-aligned part of the latched offset with the byte lane of the data-port access. The byte count is clipped so that the access never runs past the end of the 256-byte space. A target that was hot-added under a non-zero function number is hidden while function 0 of the same device is absent. The bridge issues no request when the enable flag is clear or the target is hidden. In those cases, and when no device answers, a read returns all ones across the requested bytes. Read results are right-aligned and reach the host one cycle after the read is presented.

Top module: `cfg_port_bridge`

## Requirements
- R1: The latched target word changes only on a host write with `h_sel`=0 (address port), `h_len`=4 and `h_off`=0. Writes to the address port with any other length or offset leave it unchanged.
- R2: A host read with `h_sel`=0 returns the whole 32-bit latched word on `h_rdata`, regardless of `h_len`.
- R3: After reset the latched word is zero. A data-port read then issues no request and returns all ones over the requested length.
- R4: While bit 31 of the latched word is 0, data-port accesses raise no `cfg_req`. Writes are dropped, and reads return ones in the low `h_len` bytes and zeros above them.
- R5: `cfg_bus` is bits 23:16 of the latched word and `cfg_devfn` is bits 15:8. The function number is `cfg_devfn[2:0]`. `cfg_off` is bits 7:2 of the latched word followed by `h_off` in bits 1:0.
- R6: `cfg_len` equals the smaller of `h_len` and 256 minus `cfg_off`, so `cfg_off`+`cfg_len` never exceeds 256. A length of 3 can result.
- R7: When `tgt_hotadded`=1, the function number is non-zero and `tgt_fn0_present`=0, no request is issued. Writes are discarded and reads return all ones over `h_len` bytes.
- R8: A forwarded read answered with `cfg_present`=1 returns `cfg_rdata` masked to the low `cfg_len` bytes, with upper bytes zero. With `cfg_present`=0 it returns ones over the low `h_len` bytes.
- R9: A forwarded data-port write raises `cfg_req` with `cfg_we`=1 for exactly the cycle the host access is presented, and `cfg_wdata` equals `h_wdata`.
- R10: Every host read raises `h_rvalid` in the cycle after it is presented, with the result on `h_rdata`. No host read means no `h_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_valid | input | 1 | Host access presented this cycle |
| h_write | input | 1 | 1 = write, 0 = read |
| h_sel | input | 1 | 0 = address port, 1 = data port |
| h_off | input | 2 | Byte offset within the selected port |
| h_len | input | 3 | Access length in bytes: 1, 2 or 4 |
| h_wdata | input | 32 | Host write data, right-aligned |
| h_rvalid | output | 1 | Read result valid |
| h_rdata | output | 32 | Read result, right-aligned |
| cfg_req | output | 1 | One-cycle downstream request strobe |
| cfg_we | output | 1 | Downstream request is a write |
| cfg_bus | output | 8 | Target bus number |
| cfg_devfn | output | 8 | Target device/function number |
| cfg_off | output | 8 | Byte offset in configuration space |
| cfg_len | output | 3 | Clipped byte count |
| cfg_wdata | output | 32 | Downstream write data |
| cfg_rdata | input | 32 | Downstream read data, same cycle as request |
| cfg_present | input | 1 | A device answered the request |
| tgt_hotadded | input | 1 | Addressed function was hot-added |
| tgt_fn0_present | input | 1 | Function 0 of the addressed device exists |

## Verification
The bench drives accesses near the top of configuration space, for example byte 0xFD with a 4-byte request. A bridge that fails to clip would send a count running past byte 256 instead of 3, and would return bytes the device never supplied. It covers the hidden-function rule from all sides: hot-added with function 0 missing, function 0 itself, and not hot-added. A bridge that applied the rule too broadly or too narrowly would drop or leak requests. It also sends partial writes to the address port, which must leave the word intact. Finally it issues reads against absent or disabled targets, where a wrong fill pattern or width shows up directly in `h_rdata`.

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        h_valid,
  input  logic        h_write,
  input  logic        h_sel,
  input  logic [1:0]  h_off,
  input  logic [2:0]  h_len,
  input  logic [31:0] h_wdata,
  output logic        h_rvalid,
  output logic [31:0] h_rdata,
  output logic        cfg_req,
  output logic        cfg_we,
  output logic [7:0]  cfg_bus,
  output logic [7:0]  cfg_devfn,
  output logic [7:0]  cfg_off,
  output logic [2:0]  cfg_len,
  output logic [31:0] cfg_wdata,
  input  logic [31:0] cfg_rdata,
  input  logic        cfg_present,
  input  logic        tgt_hotadded,
  input  logic        tgt_fn0_present
);

  localparam int SPACE = 256;

  logic [31:0] tgt_q;
  logic [31:0] rd_next;
  logic [8:0]  room;
  logic        tgt_wr, hidden, data_acc;

  function automatic logic [31:0] lane_mask(input logic [2:0] n);
    case (n)
      3'd1:    lane_mask = 32'h0000_00FF;
      3'd2:    lane_mask = 32'h0000_FFFF;
      3'd3:    lane_mask = 32'h00FF_FFFF;
      default: lane_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  assign tgt_wr   = h_valid & h_write & ~h_sel & (h_len == 3'd4) & (h_off == 2'd0);
  assign data_acc = h_valid & h_sel;

  assign cfg_bus   = tgt_q[23:16];
  assign cfg_devfn = tgt_q[15:8];
  assign cfg_off   = {tgt_q[7:2], h_off};
  assign room      = 9'(SPACE) - {1'b0, cfg_off};
  assign cfg_len   = ({6'd0, h_len} > room) ? room[2:0] : h_len;

  assign hidden    = tgt_hotadded & (tgt_q[10:8] != 3'd0) & ~tgt_fn0_present;
  assign cfg_req   = data_acc & tgt_q[31] & ~hidden;
  assign cfg_we    = h_write;
  assign cfg_wdata = h_wdata;

  always_comb begin
    if (!h_sel)
      rd_next = tgt_q;
    else if (cfg_req && cfg_present)
      rd_next = cfg_rdata & lane_mask(cfg_len);
    else
      rd_next = lane_mask(h_len);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_q    <= '0;
      h_rvalid <= 1'b0;
      h_rdata  <= '0;
    end else begin
      if (tgt_wr) tgt_q <= h_wdata;
      h_rvalid <= h_valid & ~h_write;
      if (h_valid && !h_write) h_rdata <= rd_next;
    end
  end

  AST_TGT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(h_valid && h_write && !h_sel && h_len == 3'd4 && h_off == 2'd0) |=> $stable(tgt_q)); // R1
  AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> tgt_q[31]); // R4
  AST_LEN_CLIP: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> ((10'(cfg_off) + 10'(cfg_len)) <= 10'd256 && cfg_len != 3'd0)); // R6
  AST_HIDDEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_hotadded && cfg_devfn[2:0] != 3'd0 && !tgt_fn0_present) |-> !cfg_req); // R7
  AST_RD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (h_valid && !h_write) |=> h_rvalid); // R10
  AST_NO_SPURIOUS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    !(h_valid && !h_write) |=> !h_rvalid); // R10
  AST_ADDR_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (h_valid && !h_write && !h_sel && !tgt_wr) |=> h_rdata == tgt_q); // R2

endmodule

// File: tb/sim_cfg_port_bridge.sv
`timescale 1ns/1ps
module sim_cfg_port_bridge;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, h_valid, h_write, h_sel;
  logic [1:0] h_off;
  logic [2:0] h_len;
  logic [31:0] h_wdata, h_rdata, cfg_wdata, cfg_rdata;
  logic h_rvalid, cfg_req, cfg_we, cfg_present, tgt_hotadded, tgt_fn0_present;
  logic [7:0] cfg_bus, cfg_devfn, cfg_off;
  logic [2:0] cfg_len;
  logic pres, hot, fn0;

  localparam logic [31:0] DEV_DATA = 32'hA1B2_C3D4;
  assign cfg_rdata       = pres ? DEV_DATA : 32'h5A5A_5A5A;
  assign cfg_present     = pres;
  assign tgt_hotadded    = hot;
  assign tgt_fn0_present = fn0;

  cfg_port_bridge u0 (.*);

  int checks = 0, errors = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  logic s_req, s_we, s_rv;
  logic [7:0] s_bus, s_devfn, s_off;
  logic [2:0] s_len;
  logic [31:0] s_wd, s_rd;

  task automatic access(input logic wr, input logic sel, input logic [1:0] off,
                        input logic [2:0] len, input logic [31:0] wd);
    @(negedge clk);
    h_valid = 1'b1; h_write = wr; h_sel = sel; h_off = off; h_len = len; h_wdata = wd;
    #1;
    s_req = cfg_req; s_we = cfg_we; s_bus = cfg_bus; s_devfn = cfg_devfn;
    s_off = cfg_off; s_len = cfg_len; s_wd = cfg_wdata;
    @(negedge clk);
    h_valid = 1'b0;
    #1;
    s_rv = h_rvalid; s_rd = h_rdata;
    check("R9 strobe single cycle", {31'd0, cfg_req}, 32'd0);
  endtask

  task automatic set_target(input logic [31:0] w);
    access(1'b1, 1'b0, 2'd0, 3'd4, w);
  endtask

  typedef struct packed {
    logic [31:0] tw;
    logic [1:0]  off;
    logic [2:0]  len;
    logic        pres, hot, fn0, req;
    logic [7:0]  eoff;
    logic [2:0]  elen;
    logic [31:0] erd;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{32'h8001_0810, 2'd0, 3'd4, 1'b1, 1'b0, 1'b1, 1'b1, 8'h10, 3'd4, 32'hA1B2_C3D4},
    '{32'h8001_0810, 2'd2, 3'd2, 1'b1, 1'b0, 1'b1, 1'b1, 8'h12, 3'd2, 32'h0000_C3D4},
    '{32'h8000_00FC, 2'd3, 3'd4, 1'b1, 1'b0, 1'b1, 1'b1, 8'hFF, 3'd1, 32'h0000_00D4},
    '{32'h8000_00FC, 2'd1, 3'd4, 1'b1, 1'b0, 1'b1, 1'b1, 8'hFD, 3'd3, 32'h00B2_C3D4},
    '{32'h0001_0810, 2'd0, 3'd4, 1'b1, 1'b0, 1'b1, 1'b0, 8'h10, 3'd4, 32'hFFFF_FFFF},
    '{32'h0001_0810, 2'd0, 3'd2, 1'b1, 1'b0, 1'b1, 1'b0, 8'h10, 3'd2, 32'h0000_FFFF},
    '{32'h8002_0B00, 2'd0, 3'd4, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 3'd4, 32'hFFFF_FFFF},
    '{32'h8002_0B00, 2'd0, 3'd4, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 3'd4, 32'hA1B2_C3D4},
    '{32'h8002_0B00, 2'd0, 3'd4, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 3'd4, 32'hA1B2_C3D4},
    '{32'h8002_0800, 2'd0, 3'd4, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 3'd4, 32'hA1B2_C3D4},
    '{32'h8003_1044, 2'd1, 3'd1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h45, 3'd1, 32'h0000_00FF},
    '{32'h80FF_FF00, 2'd0, 3'd1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 3'd1, 32'h0000_00D4}
  };

  task automatic run_all();
    rst_n = 1'b0; h_valid = 1'b0; h_write = 1'b0; h_sel = 1'b0; h_off = '0; h_len = 3'd4;
    h_wdata = '0; pres = 1'b1; hot = 1'b0; fn0 = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R3 reset state
    access(1'b0, 1'b0, 2'd0, 3'd4, '0);
    check("R3 word zero after reset", s_rd, 32'h0);
    access(1'b0, 1'b1, 2'd0, 3'd4, '0);
    check("R3 no request after reset", {31'd0, s_req}, 32'd0);
    check("R3 read ones after reset", s_rd, 32'hFFFF_FFFF);

    for (int i = 0; i < 12; i++) begin
      pres = VEC[i].pres; hot = VEC[i].hot; fn0 = VEC[i].fn0;
      set_target(VEC[i].tw);
      access(1'b0, 1'b1, VEC[i].off, VEC[i].len, '0);
      check("R4 R7 request issued", {31'd0, s_req}, {31'd0, VEC[i].req});
      if (VEC[i].req) begin
        check("R5 bus field", {24'd0, s_bus}, {24'd0, VEC[i].tw[23:16]});
        check("R5 devfn field", {24'd0, s_devfn}, {24'd0, VEC[i].tw[15:8]});
        check("R5 offset", {24'd0, s_off}, {24'd0, VEC[i].eoff});
        check("R6 clipped length", {29'd0, s_len}, {29'd0, VEC[i].elen});
      end
      check("R10 rvalid", {31'd0, s_rv}, 32'd1);
      check("R8 read data", s_rd, VEC[i].erd);
    end
    pres = 1'b1; hot = 1'b0; fn0 = 1'b1;

    // R2 readback, R1 ignored partial writes
    set_target(32'h8012_3456);
    access(1'b0, 1'b0, 2'd0, 3'd1, '0);
    check("R2 full word readback", s_rd, 32'h8012_3456);
    access(1'b1, 1'b0, 2'd0, 3'd2, 32'h0000_FFFF);
    access(1'b0, 1'b0, 2'd0, 3'd4, '0);
    check("R1 2-byte write ignored", s_rd, 32'h8012_3456);
    access(1'b1, 1'b0, 2'd1, 3'd4, 32'h1111_1111);
    access(1'b0, 1'b0, 2'd0, 3'd4, '0);
    check("R1 offset write ignored", s_rd, 32'h8012_3456);
    check("R10 rvalid on address read", {31'd0, s_rv}, 32'd1);

    // R9 forwarded write, clipped
    set_target(32'h8005_28FC);
    access(1'b1, 1'b1, 2'd2, 3'd4, 32'hCAFE_F00D);
    check("R9 write request", {31'd0, s_req}, 32'd1);
    check("R9 write flag", {31'd0, s_we}, 32'd1);
    check("R9 write data", s_wd, 32'hCAFE_F00D);
    check("R6 write clip at top", {29'd0, s_len}, 32'd2);
    check("R10 no rvalid on write", {31'd0, s_rv}, 32'd0);

    // R4 disabled write dropped
    set_target(32'h0005_28FC);
    access(1'b1, 1'b1, 2'd0, 3'd4, 32'h1234_5678);
    check("R4 disabled write dropped", {31'd0, s_req}, 32'd0);

    // R7 hidden write dropped
    set_target(32'h8005_2A00);
    hot = 1'b1; fn0 = 1'b0;
    access(1'b1, 1'b1, 2'd0, 3'd4, 32'h1234_5678);
    check("R7 hidden write dropped", {31'd0, s_req}, 32'd0);
    hot = 1'b0; fn0 = 1'b1;

    // R3 reset clears word again
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    access(1'b0, 1'b0, 2'd0, 3'd4, '0);
    check("R3 word cleared by reset", s_rd, 32'h0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule